// File: doc/BRIEF.md
# Byte Rotate Execution Unit

This block executes the two byte-rotate instructions of a small 8-bit controller core. One is a left rotate in which bit 7 wraps back into bit 0. The other is a right rotate that passes through the carry flag. A 16-bit instruction word is offered at the start of an instruction cycle. The unit decodes it and forms a 12-bit data address. The address comes from the bank register, from the split access window, or from an index register plus offset. The unit reads the operand from its internal byte file and rotates it. It then writes the result either to the working register or back to the file, and updates the carry, negative and zero flags.

Every instruction cycle has four clock phases. The first decodes, the second reads, the third computes and the fourth commits. Results and flags therefore appear together after the fourth edge. Any word that is not one of the two rotates does nothing. A load port and a peek port give the surrounding core access to the file contents and to the carry.

Top module: `rot_exec_unit`

## Requirements
- R1: Bits 15:10 of the word select the operation: 6'b010001 is rotate-left, 6'b001100 is rotate-right-through-carry. Bit 9 is the destination bit, bit 8 is the bank-mode bit and bits 7:0 are the file offset. A word with any other value in bits 15:10, or a word offered with `instr_valid_i` low, changes neither W, the flags nor the file.
- R2: `phase_o` steps 0,1,2,3,0 on every clock edge. A word is taken when `instr_valid_i` is high at an edge where `phase_o` is 0. Its destination and flags change at the fourth edge after that, and not before.
- R3: Rotate-left gives {x[6:0], x[7]} and leaves C unchanged.
- R4: Rotate-right-through-carry gives {C, x[7:1]} and loads C with x[0].
- R5: After either rotate, N equals bit 7 of the result and Z is 1 exactly when the result is 0x00.
- R6: When the destination bit is 0 the result goes to W and the file is not written. When it is 1 the result goes to the file and W is left unchanged.
- R7: When the bank-mode bit is 1, the effective address `ea_o` is {bank, offset}.
- R8: When the bank-mode bit is 0 and indexing does not apply, an offset below 0x60 gives address 0x000+offset, and any other offset gives 0xF00+offset.
- R9: When the bank-mode bit is 0, `idx_mode_en_i` is 1 and the offset is at most 0x5F, the address is (index + offset) modulo 4096.
- R10: After reset, W, C, N, Z, `ea_o`, `phase_o` and every file byte are 0.
- R11: The file holds 256 bytes, indexed by the low 8 bits of the effective address. Addresses that share those bits refer to the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present at a phase-0 edge |
| instr_i | input | 16 | Instruction word |
| bsr_i | input | 4 | Bank register, upper address bits |
| fsr2_i | input | 12 | Index register for offset addressing |
| idx_mode_en_i | input | 1 | Enables indexed offset addressing |
| c_ld_en_i | input | 1 | Load carry from c_ld_val_i |
| c_ld_val_i | input | 1 | Carry load value |
| poke_en_i | input | 1 | Write a file byte from outside |
| poke_idx_i | input | 8 | File index for the outside write |
| poke_data_i | input | 8 | Data for the outside write |
| peek_idx_i | input | 8 | File index for the outside read |
| peek_data_o | output | 8 | File byte at peek_idx_i |
| phase_o | output | 2 | Current phase, 0 to 3 |
| ea_o | output | 12 | Effective address of the last instruction |
| w_o | output | 8 | Working register |
| c_o | output | 1 | Carry flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |

## Verification
The bench checks the access-window boundary on both sides of 0x5F/0x60, with and without indexing. A wrong comparison would send offset 0x5F or 0x60 into the wrong bank, or index an offset that should not be indexed. An indexed address whose sum overflows 12 bits must wrap; carrying a thirteenth bit would land in the wrong place. For the carry, the bench checks that the incoming carry reaches bit 7 and that bit 0 reaches C on the right rotate, and that the left rotate does not touch C. Finally it checks that no commit happens at phase 3, that invalid opcodes do nothing, and that the destination bit never writes both W and the file.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned IW = 16;
  localparam logic [5:0] OPC_ROL  = 6'b010001;
  localparam logic [5:0] OPC_RORC = 6'b001100;
  localparam logic [7:0] ACC_SPLIT = 8'h60;
  localparam logic [7:0] IDX_LIMIT = 8'h5F;

  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;
  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_ROL = 2'd1, OP_RORC = 2'd2} op_e;

  typedef struct packed {
    op_e           op;
    logic          to_file;
    logic          use_bank;
    logic [DW-1:0] faddr;
  } dec_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
(
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o.to_file  = instr_i[9];
    dec_o.use_bank = instr_i[8];
    dec_o.faddr    = instr_i[7:0];
    unique case (instr_i[15:10])
      OPC_ROL:  dec_o.op = OP_ROL;
      OPC_RORC: dec_o.op = OP_RORC;
      default:  dec_o.op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/rot_addr_gen.sv
module rot_addr_gen
  import rot_pkg::*;
#(
  parameter int unsigned AW = 12,
  localparam int unsigned BW = AW - DW
) (
  input  logic          use_bank_i,
  input  logic [DW-1:0] faddr_i,
  input  logic [BW-1:0] bank_i,
  input  logic [AW-1:0] index_i,
  input  logic          idx_en_i,
  output logic [AW-1:0] ea_o
);
  logic          indexed;
  logic [AW-1:0] idx_sum;

  assign indexed = !use_bank_i && idx_en_i && (faddr_i <= IDX_LIMIT);
  assign idx_sum = index_i + AW'(faddr_i);  // wraps at AW bits

  always_comb begin
    if (use_bank_i)              ea_o = {bank_i, faddr_i};
    else if (indexed)            ea_o = idx_sum;
    else if (faddr_i < ACC_SPLIT) ea_o = {{BW{1'b0}}, faddr_i};
    else                          ea_o = {{BW{1'b1}}, faddr_i};
  end
endmodule

// File: rtl/rot_alu.sv
module rot_alu
  import rot_pkg::*;
(
  input  op_e           op_i,
  input  logic [DW-1:0] src_i,
  input  logic          c_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          n_o,
  output logic          z_o
);
  always_comb begin
    res_o = src_i;
    c_o   = c_i;
    unique case (op_i)
      OP_ROL:  res_o = {src_i[DW-2:0], src_i[DW-1]};
      OP_RORC: begin
        res_o = {c_i, src_i[DW-1:1]};
        c_o   = src_i[0];
      end
      default: ;
    endcase
    n_o = res_o[DW-1];
    z_o = (res_o == '0);
  end
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile
  import rot_pkg::*;
#(
  parameter int unsigned FAW = 8,
  localparam int unsigned DEPTH = 1 << FAW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [FAW-1:0] wr_idx_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           poke_en_i,
  input  logic [FAW-1:0] poke_idx_i,
  input  logic [DW-1:0]  poke_data_i,
  input  logic [FAW-1:0] rd_idx_i,
  output logic [DW-1:0]  rd_data_o,
  input  logic [FAW-1:0] peek_idx_i,
  output logic [DW-1:0]  peek_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == FAW'(g))          mem_q[g] <= wr_data_i;  // core write wins
      else if (poke_en_i && poke_idx_i == FAW'(g))      mem_q[g] <= poke_data_i;
    end
  end

  assign rd_data_o   = mem_q[rd_idx_i];
  assign peek_data_o = mem_q[peek_idx_i];
endmodule

// File: rtl/rot_exec_unit.sv
module rot_exec_unit
  import rot_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned FAW = 8,
  localparam int unsigned BW = AW - DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           instr_valid_i,
  input  logic [IW-1:0]  instr_i,
  input  logic [BW-1:0]  bsr_i,
  input  logic [AW-1:0]  fsr2_i,
  input  logic           idx_mode_en_i,
  input  logic           c_ld_en_i,
  input  logic           c_ld_val_i,
  input  logic           poke_en_i,
  input  logic [FAW-1:0] poke_idx_i,
  input  logic [DW-1:0]  poke_data_i,
  input  logic [FAW-1:0] peek_idx_i,
  output logic [DW-1:0]  peek_data_o,
  output logic [1:0]     phase_o,
  output logic [AW-1:0]  ea_o,
  output logic [DW-1:0]  w_o,
  output logic           c_o,
  output logic           n_o,
  output logic           z_o
);
  phase_e        phase_q;
  dec_t          dec_now, dec_q;
  logic          ir_vld_q;
  logic [AW-1:0] ea_now, ea_q;
  logic [DW-1:0] opnd_q, rd_data;
  logic [DW-1:0] alu_res, res_q, w_q;
  logic          alu_c, alu_n, alu_z;
  logic          cres_q, nres_q, zres_q;
  logic          c_q, n_q, z_q;
  logic          commit, rf_we;

  rot_decode u_dec (.instr_i(instr_i), .dec_o(dec_now));

  rot_addr_gen #(.AW(AW)) u_agen (
    .use_bank_i(dec_q.use_bank), .faddr_i(dec_q.faddr), .bank_i(bsr_i),
    .index_i(fsr2_i), .idx_en_i(idx_mode_en_i), .ea_o(ea_now)
  );

  rot_regfile #(.FAW(FAW)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(rf_we), .wr_idx_i(ea_q[FAW-1:0]), .wr_data_i(res_q),
    .poke_en_i(poke_en_i), .poke_idx_i(poke_idx_i), .poke_data_i(poke_data_i),
    .rd_idx_i(ea_now[FAW-1:0]), .rd_data_o(rd_data),
    .peek_idx_i(peek_idx_i), .peek_data_o(peek_data_o)
  );

  rot_alu u_alu (
    .op_i(dec_q.op), .src_i(opnd_q), .c_i(c_q),
    .res_o(alu_res), .c_o(alu_c), .n_o(alu_n), .z_o(alu_z)
  );

  assign commit = (phase_q == PH_Q4) && ir_vld_q;
  assign rf_we  = commit && dec_q.to_file;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_Q1;
    else         phase_q <= phase_e'(phase_q + 2'd1);
  end

  // Q1: decode and latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_vld_q <= 1'b0;
      dec_q    <= '0;
    end else if (phase_q == PH_Q1) begin
      ir_vld_q <= instr_valid_i && (dec_now.op != OP_NOP);
      dec_q    <= dec_now;
    end
  end

  // Q2: address and operand read; Q3: compute
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_q   <= '0;
      opnd_q <= '0;
      res_q  <= '0;
      cres_q <= 1'b0;
      nres_q <= 1'b0;
      zres_q <= 1'b0;
    end else begin
      if (phase_q == PH_Q2 && ir_vld_q) begin
        ea_q   <= ea_now;
        opnd_q <= rd_data;
      end
      if (phase_q == PH_Q3) begin
        res_q  <= alu_res;
        cres_q <= alu_c;
        nres_q <= alu_n;
        zres_q <= alu_z;
      end
    end
  end

  // Q4: commit destination and flags together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q <= '0;
      c_q <= 1'b0;
      n_q <= 1'b0;
      z_q <= 1'b0;
    end else if (commit) begin
      if (!dec_q.to_file) w_q <= res_q;
      c_q <= cres_q;
      n_q <= nres_q;
      z_q <= zres_q;
    end else if (c_ld_en_i) begin
      c_q <= c_ld_val_i;
    end
  end

  assign phase_o = phase_q;
  assign ea_o    = ea_q;
  assign w_o     = w_q;
  assign c_o     = c_q;
  assign n_o     = n_q;
  assign z_o     = z_q;

  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_q == phase_e'($past(phase_q) + 2'd1));

  p_nop_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_Q4 && !ir_vld_q && !c_ld_en_i) |=> $stable({w_q, c_q, n_q, z_q}));

  p_rol_keeps_c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && dec_q.op == OP_ROL) |=> $stable(c_q));

  p_flags_track_w_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !dec_q.to_file) |=> (z_q == (w_q == '0)) && (n_q == w_q[DW-1]));

  p_w_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && dec_q.to_file) |=> $stable(w_q));

  p_no_early_commit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_Q4 && !c_ld_en_i) |=> $stable({w_q, c_q, n_q, z_q}));
endmodule

// File: tb/rot_exec_unit_bench.sv
module rot_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  bsr = '0;
  logic [11:0] fsr2 = '0;
  logic        idx_en = 1'b0;
  logic        c_ld_en = 1'b0, c_ld_val = 1'b0;
  logic        poke_en = 1'b0;
  logic [7:0]  poke_idx = '0, poke_data = '0, peek_idx = '0;
  logic [7:0]  peek_data, w;
  logic [1:0]  phase;
  logic [11:0] ea;
  logic        c, n, z;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rot_exec_unit u_rot_exec_unit (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .bsr_i(bsr), .fsr2_i(fsr2), .idx_mode_en_i(idx_en),
    .c_ld_en_i(c_ld_en), .c_ld_val_i(c_ld_val),
    .poke_en_i(poke_en), .poke_idx_i(poke_idx), .poke_data_i(poke_data),
    .peek_idx_i(peek_idx), .peek_data_o(peek_data),
    .phase_o(phase), .ea_o(ea), .w_o(w), .c_o(c), .n_o(n), .z_o(z)
  );

  // instr, bsr, fsr2, ext, cin, operand | exp ea, exp result, exp carry
  localparam int NV = 8;
  localparam logic [62:0] VEC [NV] = '{
    {16'h4725, 4'h3, 12'h000, 1'b0, 1'b0, 8'hAB, 12'h325, 8'h57, 1'b0},
    {16'h4410, 4'h7, 12'h000, 1'b0, 1'b1, 8'h80, 12'h010, 8'h01, 1'b1},
    {16'h3070, 4'h2, 12'h000, 1'b0, 1'b0, 8'hE6, 12'hF70, 8'h73, 1'b0},
    {16'h3381, 4'hA, 12'h000, 1'b1, 1'b0, 8'h01, 12'hA81, 8'h00, 1'b1},
    {16'h3220, 4'h0, 12'h3F0, 1'b1, 1'b1, 8'h02, 12'h410, 8'h81, 1'b0},
    {16'h445F, 4'h0, 12'hFF0, 1'b1, 1'b0, 8'h00, 12'h04F, 8'h00, 1'b0},
    {16'h4660, 4'h0, 12'h123, 1'b1, 1'b1, 8'h7F, 12'hF60, 8'hFE, 1'b1},
    {16'h305F, 4'h0, 12'h123, 1'b0, 1'b1, 8'hFF, 12'h05F, 8'hFF, 1'b1}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] idx, output logic [7:0] val);
    peek_idx = idx;
    #1 val = peek_data;
  endtask

  task automatic setup(logic [7:0] idx, logic [7:0] val, logic cin);
    while (phase != 2'd0) @(negedge clk);
    poke_en = 1'b1; poke_idx = idx; poke_data = val;
    c_ld_en = 1'b1; c_ld_val = cin;
    @(negedge clk);
    poke_en = 1'b0; c_ld_en = 1'b0;
  endtask

  // offers the word at a phase-0 edge, returns at the negedge after the fourth edge
  task automatic run(logic [15:0] word, logic vld);
    while (phase != 2'd0) @(negedge clk);
    instr = word; instr_valid = vld;
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, wb;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 phase", phase, 0);
    check("R10 w", w, 0);
    check("R10 flags", {c, n, z}, 0);
    check("R10 ea", ea, 0);
    peek(8'h33, v);
    check("R10 file", v, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 phase sequence
    while (phase != 2'd0) @(negedge clk);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      check("R2 phase step", phase, i % 4);
    end

    for (int k = 0; k < NV; k++) begin
      logic [15:0] wd; logic [7:0] opnd, res; logic [11:0] xea; logic cin, xc;
      {wd, bsr, fsr2, idx_en, cin, opnd, xea, res, xc} = VEC[k];
      setup(xea[7:0], opnd, cin);
      wb = w;
      run(wd, 1'b1);
      check("R7 R8 R9 ea", ea, xea);
      check(wd[10] ? "R3 carry" : "R4 carry", c, xc);
      check("R5 n", n, res[7]);
      check("R5 z", z, res == 8'h00);
      peek(xea[7:0], v);
      if (wd[9]) begin
        check(wd[10] ? "R3 R6 file" : "R4 R6 file", v, res);
        check("R6 w kept", w, wb);
      end else begin
        check(wd[10] ? "R3 R6 w" : "R4 R6 w", w, res);
        check("R6 file kept", v, opnd);
      end
    end

    // R2 no commit before the fourth edge
    bsr = 4'h0; fsr2 = '0; idx_en = 1'b0;
    setup(8'h44, 8'h0F, 1'b0);
    wb = w;
    while (phase != 2'd0) @(negedge clk);
    instr = 16'h4444; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 w before commit", w, wb);
    @(negedge clk);
    check("R2 w at commit", w, 8'h1E);
    check("R5 n z", {n, z}, 2'b00);

    // R1 invalid opcode and unflagged word do nothing
    wb = w;
    setup(8'h44, 8'h0F, 1'b1);
    run(16'h4844, 1'b1);
    check("R1 nop w", w, wb);
    check("R1 nop flags", {c, n, z}, 3'b100);
    peek(8'h44, v);
    check("R1 nop file", v, 8'h0F);
    run(16'h4744, 1'b0);
    peek(8'h44, v);
    check("R1 invalid strobe file", v, 8'h0F);
    check("R1 invalid strobe w", w, wb);

    // R11 aliasing: bank 5 offset 0x44 hits file byte 0x44
    bsr = 4'h5;
    run(16'h4744, 1'b1);
    check("R11 ea", ea, 12'h544);
    peek(8'h44, v);
    check("R11 alias file", v, 8'h1E);
    check("R3 carry held", c, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule